// File: doc/BRIEF.md
# FIFO Threshold Interrupt and DMA Request Controller

This block sits between a register bus and a serial shift engine. It holds one byte-wide transmit FIFO and one byte-wide receive FIFO, each `DEPTH` entries deep (64 or 128). Software, or a DMA engine, writes bytes into a transmit data window and reads bytes from a receive data window. The shift engine pops transmit bytes, pushes received bytes and signals the end of a transfer with a one-cycle event.

Each FIFO has one 8-bit trigger level. That level drives both the FIFO's event status bit and its DMA request line. Four event bits are held in a status register: receive-ready, transmit-request, receive-overflow and transfer-done. A status bit is cleared only by writing a one to it, so a level condition that still holds sets its bit again. One interrupt line combines every enabled pending event.

Top module: `xfer_fifo_ctrl`

## Requirements
- R1: A write to the transmit window (select 4) appends `busWdata[7:0]` unless the FIFO holds `DEPTH` bytes, in which case the byte is dropped. `txData` shows the oldest byte, or 0 when the FIFO is empty, and `txValid` is high while it is not empty. `txPop` removes the oldest byte and is ignored when the FIFO is empty. The transmit count reads back in bits [23:16] of the level register (select 3).
- R2: An `rxPush` appends `rxPushData` when the receive FIFO is not full. A read of the receive window (select 5) returns the oldest byte in bits [7:0] and removes it. When the FIFO is empty that read returns 0 and removes nothing. The receive count reads back in bits [7:0] of the level register.
- R3: An `rxPush` that arrives while the receive FIFO holds `DEPTH` bytes drops the byte and sets status bit 8 (overflow).
- R4: In the control register (select 0), writing 1 to bit 15 empties the receive FIFO and writing 1 to bit 31 empties the transmit FIFO, both at the next edge. Neither bit is stored, and both read back as 0.
- R5: Status bit 0 (receive-ready) is set at the edge after any cycle in which the receive count is at or above the receive trigger level, which is control bits [7:0].
- R6: Status bit 4 (transmit-request) is set at the edge after any cycle in which the transmit count is at or below the transmit trigger level, which is control bits [23:16].
- R7: A `doneEvt` pulse sets status bit 12 at the next edge.
- R8: A write to the status register (select 2) clears each event bit whose data bit is 1 and leaves bits written 0 unchanged. A set condition in the same cycle wins over the clear.
- R9: The interrupt enable register (select 1) uses the same bit positions as the status register (0, 4, 8, 12). `irq` is high exactly when at least one status bit and its enable are both 1.
- R10: `rxDmaReq` equals control bit 8 AND (receive count ≥ receive trigger level). `txDmaReq` equals control bit 24 AND (transmit count ≤ transmit trigger level). Both follow the current counts with no added register stage.
- R11: After reset both FIFOs are empty and the control, enable and status registers are 0. `irq` and both DMA requests are low while reset is held.
- R12: `busRdata` is combinational from `busAddr`. Select 0 returns the control fields, 1 the enables, 2 the status and 3 the levels; 4 and any unused select return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register select |
| busWrite | input | 1 | Write strobe |
| busRead | input | 1 | Read strobe (pops the receive window) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data |
| txPop | input | 1 | Shift engine takes a transmit byte |
| txData | output | 8 | Oldest transmit byte |
| txValid | output | 1 | Transmit FIFO not empty |
| rxPush | input | 1 | Shift engine delivers a received byte |
| rxPushData | input | 8 | Received byte |
| doneEvt | input | 1 | Transfer-complete pulse |
| irq | output | 1 | Interrupt |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |

## Verification
The bench drives the receive FIFO into overflow at exactly `DEPTH` bytes. A design whose full test is off by one would either raise overflow a byte early or store a 65th byte. Status is cleared while its level condition still holds, so a design that let the clear win would show a ready bit dropping out even though data is waiting. Flush writes are mixed with pushes, pops and trigger changes. A flush bit that is stored would read back 1, and a DMA request registered one cycle late would miss the per-cycle comparison. Bounded random traffic then runs trigger levels across both FIFO ends, including 0 and values above `DEPTH`.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;
  localparam logic [2:0] SelCtrl  = 3'd0;
  localparam logic [2:0] SelIen   = 3'd1;
  localparam logic [2:0] SelSta   = 3'd2;
  localparam logic [2:0] SelLevel = 3'd3;
  localparam logic [2:0] SelTxWin = 3'd4;
  localparam logic [2:0] SelRxWin = 3'd5;

  // event positions inside the 32-bit enable/status words
  localparam int EvtCount = 4;
  localparam int EvtStride = 4;

  typedef struct packed {
    logic       txWr;
    logic       rxRd;
    logic       txFlush;
    logic       rxFlush;
    logic [7:0] wrByte;
  } dpStrobes_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [7:0]    pushData,
  input  logic          pop,
  input  logic          flush,
  output logic [7:0]    headData,
  output logic [CW-1:0] count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          full, empty, pushOk, popOk;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign pushOk = push && !full && !flush;
  assign popOk  = pop && !empty && !flush;

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= wrPtr + AW'(1);
      if (popOk)  rdPtr <= rdPtr + AW'(1);
      count <= count + CW'(pushOk) - CW'(popOk);
    end
  end

  assign headData = empty ? 8'h00 : mem[rdPtr];
endmodule

// File: rtl/xfer_fifo_dp.sv
module xfer_fifo_dp
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobes_t    strb,
  input  logic          txPop,
  input  logic          rxPush,
  input  logic [7:0]    rxPushData,
  output logic [7:0]    txHead,
  output logic          txValid,
  output logic [7:0]    rxHead,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount,
  output logic          rxOverflow
);
  byte_fifo #(.DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN),
    .push(strb.txWr), .pushData(strb.wrByte),
    .pop(txPop), .flush(strb.txFlush),
    .headData(txHead), .count(txCount)
  );

  byte_fifo #(.DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN),
    .push(rxPush), .pushData(rxPushData),
    .pop(strb.rxRd), .flush(strb.rxFlush),
    .headData(rxHead), .count(rxCount)
  );

  assign txValid    = (txCount != '0);
  assign rxOverflow = rxPush && (rxCount == CW'(DEPTH));
endmodule

// File: rtl/xfer_fifo_ctl.sv
module xfer_fifo_ctl
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          busAddr,
  input  logic                busWrite,
  input  logic                busRead,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic                doneEvt,
  input  logic [7:0]          rxHead,
  input  logic [CW-1:0]       txCount,
  input  logic [CW-1:0]       rxCount,
  input  logic                rxOverflow,
  output dpStrobes_t          strb,
  output logic [EvtCount-1:0] evtStatus,
  output logic                irq,
  output logic                txDmaReq,
  output logic                rxDmaReq
);
  logic [7:0]          rxTrig, txTrig;
  logic                rxDmaEn, txDmaEn;
  logic [EvtCount-1:0] evtEnable, evtSet, evtClr;
  logic [7:0]          rxLevel, txLevel;
  logic                rxCond, txCond;
  logic                wrCtrl, wrIen, wrSta;
  logic [31:0]         ienWord, staWord;

  assign wrCtrl = busWrite && (busAddr == SelCtrl);
  assign wrIen  = busWrite && (busAddr == SelIen);
  assign wrSta  = busWrite && (busAddr == SelSta);

  assign strb.txWr    = busWrite && (busAddr == SelTxWin);
  assign strb.rxRd    = busRead && (busAddr == SelRxWin);
  assign strb.txFlush = wrCtrl && busWdata[31];
  assign strb.rxFlush = wrCtrl && busWdata[15];
  assign strb.wrByte  = busWdata[7:0];

  assign rxLevel = 8'(rxCount);
  assign txLevel = 8'(txCount);
  assign rxCond  = (rxLevel >= rxTrig);
  assign txCond  = (txLevel <= txTrig);

  assign evtSet = {doneEvt, rxOverflow, txCond, rxCond};

  // spread the compact event vectors onto the 32-bit register layout
  for (genvar e = 0; e < EvtCount; e++) begin : g_evtMap
    assign evtClr[e] = wrSta && busWdata[e*EvtStride];
    always_comb begin
      ienWord[e*EvtStride +: EvtStride] = {{(EvtStride-1){1'b0}}, evtEnable[e]};
      staWord[e*EvtStride +: EvtStride] = {{(EvtStride-1){1'b0}}, evtStatus[e]};
    end
  end
  assign ienWord[31:EvtCount*EvtStride] = '0;
  assign staWord[31:EvtCount*EvtStride] = '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxTrig    <= '0;
      txTrig    <= '0;
      rxDmaEn   <= 1'b0;
      txDmaEn   <= 1'b0;
      evtEnable <= '0;
      evtStatus <= '0;
    end else begin
      if (wrCtrl) begin
        rxTrig  <= busWdata[7:0];
        rxDmaEn <= busWdata[8];
        txTrig  <= busWdata[23:16];
        txDmaEn <= busWdata[24];
      end
      if (wrIen) begin
        for (int e = 0; e < EvtCount; e++) evtEnable[e] <= busWdata[e*EvtStride];
      end
      evtStatus <= (evtStatus & ~evtClr) | evtSet;
    end
  end

  assign irq      = |(evtStatus & evtEnable);
  assign rxDmaReq = rxDmaEn && rxCond;
  assign txDmaReq = txDmaEn && txCond;

  always_comb begin
    case (busAddr)
      SelCtrl:  busRdata = {7'd0, txDmaEn, txTrig, 7'd0, rxDmaEn, rxTrig};
      SelIen:   busRdata = ienWord;
      SelSta:   busRdata = staWord;
      SelLevel: busRdata = {8'd0, txLevel, 8'd0, rxLevel};
      SelRxWin: busRdata = {24'd0, rxHead};
      default:  busRdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/xfer_fifo_ctrl.sv
module xfer_fifo_ctrl
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  busAddr,
  input  logic        busWrite,
  input  logic        busRead,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        txPop,
  output logic [7:0]  txData,
  output logic        txValid,
  input  logic        rxPush,
  input  logic [7:0]  rxPushData,
  input  logic        doneEvt,
  output logic        irq,
  output logic        txDmaReq,
  output logic        rxDmaReq
);
  localparam int CW = $clog2(DEPTH + 1);

  dpStrobes_t          strb;
  logic [CW-1:0]       txCount, rxCount;
  logic [7:0]          rxHead;
  logic                rxOverflow;
  logic [EvtCount-1:0] evtStatus;

  xfer_fifo_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txPop(txPop), .rxPush(rxPush), .rxPushData(rxPushData),
    .txHead(txData), .txValid(txValid), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount), .rxOverflow(rxOverflow)
  );

  xfer_fifo_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrite(busWrite), .busRead(busRead),
    .busWdata(busWdata), .busRdata(busRdata), .doneEvt(doneEvt),
    .rxHead(rxHead), .txCount(txCount), .rxCount(rxCount),
    .rxOverflow(rxOverflow), .strb(strb), .evtStatus(evtStatus),
    .irq(irq), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );
endmodule

// File: rtl/xfer_fifo_chk.sv
module xfer_fifo_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic [2:0]    busAddr,
  input logic          busWrite,
  input logic          busRead,
  input logic [31:0]   busWdata,
  input logic          rxPush,
  input logic          doneEvt,
  input logic          irq,
  input logic [CW-1:0] txCount,
  input logic [CW-1:0] rxCount,
  input logic [3:0]    evtStatus
);
  logic rxFlushWr, rxPopRd;
  assign rxFlushWr = busWrite && (busAddr == 3'd0) && busWdata[15];
  assign rxPopRd   = busRead && (busAddr == 3'd5);

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CW'(DEPTH)) && (rxCount <= CW'(DEPTH)));

  assert_rx_push_grows_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxPush && (rxCount < CW'(DEPTH)) && !rxPopRd && !rxFlushWr
    |=> rxCount == $past(rxCount) + CW'(1));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxPush && (rxCount == CW'(DEPTH)) |=> evtStatus[2] && (rxCount != '0 || $past(rxFlushWr || rxPopRd)));

  assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxFlushWr |=> rxCount == '0);

  assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |=> evtStatus[3]);

  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && (busAddr == 3'd2) && busWdata[12] && !doneEvt |=> !evtStatus[3]);

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> evtStatus != 4'd0);
endmodule

bind xfer_fifo_ctrl xfer_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
  .busRead(busRead), .busWdata(busWdata), .rxPush(rxPush),
  .doneEvt(doneEvt), .irq(irq), .txCount(txCount), .rxCount(rxCount),
  .evtStatus(evtStatus)
);

// File: tb/test_xfer_fifo_ctrl.sv
module test_xfer_fifo_ctrl;
  localparam int ClkPeriod = 10;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrite = 1'b0, busRead = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        txPop = 1'b0, rxPush = 1'b0, doneEvt = 1'b0;
  logic [7:0]  rxPushData = '0;
  logic [7:0]  txData;
  logic        txValid, irq, txDmaReq, rxDmaReq;

  int checks = 0, fails = 0;
  logic [31:0] lastRd;

  // reference model state
  logic [7:0]  txQ[$], rxQ[$];
  int          rxTrig = 0, txTrig = 0;
  bit          rxDmaEn = 0, txDmaEn = 0;
  logic [31:0] ien = '0, sta = '0;

  always #(ClkPeriod/2) clk = ~clk;

  xfer_fifo_ctrl #(.DEPTH(DEPTH)) i_xfer_fifo_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busWdata(busWdata), .busRdata(busRdata),
    .txPop(txPop), .txData(txData), .txValid(txValid),
    .rxPush(rxPush), .rxPushData(rxPushData), .doneEvt(doneEvt),
    .irq(irq), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mRead(logic [2:0] a);
    case (a)
      3'd0: return {7'd0, txDmaEn, 8'(txTrig), 7'd0, rxDmaEn, 8'(rxTrig)};
      3'd1: return ien;
      3'd2: return sta;
      3'd3: return {8'd0, 8'(txQ.size()), 8'd0, 8'(rxQ.size())};
      3'd5: return rxQ.size() > 0 ? {24'd0, rxQ[0]} : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rdTag(logic [2:0] a);
    case (a)
      3'd0: return "R4 control readback";
      3'd1: return "R9 enable readback";
      3'd2: return "R8 status readback";
      3'd3: return "R1 level readback";
      3'd5: return "R2 receive window";
      default: return "R12 unused select";
    endcase
  endfunction

  task automatic modelEdge();
    int rxN = rxQ.size();
    int txN = txQ.size();
    logic [31:0] setV = '0, clrV = '0;
    if (rxN >= rxTrig) setV[0] = 1'b1;
    if (txN <= txTrig) setV[4] = 1'b1;
    if (rxPush && rxN == DEPTH) setV[8] = 1'b1;
    if (doneEvt) setV[12] = 1'b1;
    if (busWrite && busAddr == 3'd2) clrV = busWdata & 32'h1111;
    sta = (sta & ~clrV) | setV;
    if (busWrite && busAddr == 3'd0 && busWdata[31]) txQ.delete();
    else begin
      if (txPop && txN > 0) void'(txQ.pop_front());
      if (busWrite && busAddr == 3'd4 && txN < DEPTH) txQ.push_back(busWdata[7:0]);
    end
    if (busWrite && busAddr == 3'd0 && busWdata[15]) rxQ.delete();
    else begin
      if (busRead && busAddr == 3'd5 && rxN > 0) void'(rxQ.pop_front());
      if (rxPush && rxN < DEPTH) rxQ.push_back(rxPushData);
    end
    if (busWrite && busAddr == 3'd0) begin
      rxTrig = int'(busWdata[7:0]); rxDmaEn = busWdata[8];
      txTrig = int'(busWdata[23:16]); txDmaEn = busWdata[24];
    end
    if (busWrite && busAddr == 3'd1) ien = busWdata & 32'h1111;
  endtask

  // one clock: compare everything before the edge, then advance the model
  task automatic step();
    #1;
    lastRd = busRdata;
    check(rdTag(busAddr), busRdata, mRead(busAddr));
    check("R9 irq", {31'd0, irq}, {31'd0, |(sta & ien)});
    check("R10 rx dma", {31'd0, rxDmaReq}, {31'd0, rxDmaEn && rxQ.size() >= rxTrig});
    check("R10 tx dma", {31'd0, txDmaReq}, {31'd0, txDmaEn && txQ.size() <= txTrig});
    check("R1 tx head", {24'd0, txData}, txQ.size() > 0 ? {24'd0, txQ[0]} : 32'd0);
    check("R1 tx valid", {31'd0, txValid}, {31'd0, txQ.size() > 0});
    @(posedge clk);
    if (rstN) modelEdge();
    @(negedge clk);
  endtask

  task automatic busWr(logic [2:0] a, logic [31:0] d);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    step();
    busWrite = 1'b0;
  endtask

  task automatic busRd(logic [2:0] a);
    busAddr = a; busRead = 1'b1;
    step();
    busRead = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(ClkPeriod * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    idle(3);
    check("R11 irq in reset", {31'd0, irq}, 32'd0);
    check("R11 dma in reset", {30'd0, txDmaReq, rxDmaReq}, 32'd0);
    rstN = 1'b1;
    idle(2);
    busRd(3'd0);
    check("R11 control after reset", lastRd, 32'd0);
    busRd(3'd2);
    check("R5 R6 trigger zero status", lastRd, 32'h11);

    busWr(3'd0, 32'h0102_0104);
    busWr(3'd2, 32'hFFFF_FFFF);
    busRd(3'd2);
    check("R8 clear with condition held", lastRd, 32'h10);

    rxPush = 1'b1;
    for (int i = 0; i < 4; i++) begin rxPushData = 8'hA0 + 8'(i); step(); end
    rxPush = 1'b0;
    check("R10 rx dma at trigger", {31'd0, rxDmaReq}, 32'd1);
    idle(1);
    busRd(3'd2);
    check("R5 rx ready set", lastRd, 32'h11);
    busRd(3'd5);
    check("R2 oldest byte", lastRd, 32'hA0);

    rxPush = 1'b1;
    for (int i = 0; i < 62; i++) begin rxPushData = 8'(i); step(); end
    rxPush = 1'b0;
    idle(1);
    busRd(3'd2);
    check("R3 overflow flag", {31'd0, lastRd[8]}, 32'd1);
    busRd(3'd3);
    check("R12 level word full rx", lastRd, 32'h40);

    busWr(3'd0, 32'h0102_8104);
    busRd(3'd3);
    check("R4 rx flushed", lastRd, 32'h0);
    busRd(3'd0);
    check("R4 flush bit not stored", lastRd, 32'h0102_0104);
    busRd(3'd5);
    check("R2 empty read returns zero", lastRd, 32'h0);

    busWr(3'd4, 32'h11); busWr(3'd4, 32'h22); busWr(3'd4, 32'h33);
    check("R1 head byte", {24'd0, txData}, 32'h11);
    txPop = 1'b1; step(); txPop = 1'b0;
    check("R1 pop advances head", {24'd0, txData}, 32'h22);
    check("R10 tx dma at trigger", {31'd0, txDmaReq}, 32'd1);
    busWr(3'd4, 32'h44);
    check("R10 tx dma above trigger", {31'd0, txDmaReq}, 32'd0);
    idle(1);
    busWr(3'd2, 32'h10);
    busRd(3'd2);
    check("R6 tx request cleared when above level", lastRd[4], 1'b0);

    busWr(3'd1, 32'h1000);
    doneEvt = 1'b1; step(); doneEvt = 1'b0;
    check("R7 done raises irq", {31'd0, irq}, 32'd1);
    busWr(3'd2, 32'h0000_0001);
    check("R8 zero bits leave done pending", {31'd0, irq}, 32'd1);
    busWr(3'd2, 32'h1000);
    check("R8 done cleared", {31'd0, irq}, 32'd0);

    for (int i = 0; i < 70; i++) busWr(3'd4, 32'(i));
    busRd(3'd3);
    check("R1 tx saturates at depth", lastRd, 32'h0040_0000);

    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 99);
      busAddr  = 3'($urandom_range(0, 6));
      busWrite = sel < 30;
      busRead  = (sel >= 20) && (sel < 50);
      busWdata = $urandom;
      if (busAddr == 3'd0) begin
        busWdata[7:0]   = 8'($urandom_range(0, 70));
        busWdata[23:16] = 8'($urandom_range(0, 70));
        busWdata[15]    = ($urandom_range(0, 9) == 0);
        busWdata[31]    = ($urandom_range(0, 9) == 0);
      end
      txPop      = ($urandom_range(0, 2) == 0);
      rxPush     = ($urandom_range(0, 1) == 0);
      rxPushData = 8'($urandom);
      doneEvt    = ($urandom_range(0, 30) == 0);
      step();
    end
    busWrite = 1'b0; busRead = 1'b0; txPop = 1'b0; rxPush = 1'b0; doneEvt = 1'b0;
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule